// File: doc/BRIEF.md
# USB Data Packet Serializer

This block turns the payload held in a transmit FIFO into the byte stream of one USB data packet. It sends a PID byte, then the payload bytes in FIFO order, then a 16-bit CRC, then an end-of-packet marker. Firmware loads only the payload. The block picks the PID, computes the CRC over the payload and pops the FIFO itself. Bit-level NRZI coding and bit stuffing happen downstream and are not part of this block.

A packet begins with a one-cycle start pulse while the block is idle. The FIFO has a show-ahead read port: the head byte is visible whenever the FIFO is not empty. A level flag tells the block that the whole packet has been written. Because of this flag, firmware can keep feeding the FIFO while the packet is already going out. If the FIFO runs dry while the flag is still clear, the block aborts the packet: it emits a forced stuff-error strobe and then an end-of-packet marker instead of the CRC. A packet that ends normally clears the flag through a one-cycle strobe. Every packet, normal or aborted, ends with a done pulse that carries an abort indicator.

The downstream serializer accepts one output item per clock cycle. No output handshake is needed.

Top module: `usb_data_pkt_ser`

## Requirements
- R1: After reset, `tx_valid_o`, `stuff_err_o`, `eop_o`, `done_o`, `aborted_o`, `last_clr_o` and `fifo_rd_o` are all low, and the block is idle.
- R2: In non-isochronous mode (`iso_i`=0), the first valid byte is the PID byte, one cycle after the start pulse is sampled. The PID byte is 0xC3 (DATA0) when `toggle_i`=0 and 0x4B (DATA1) when `toggle_i`=1. Each PID byte is the 4-bit PID code in the low nibble with its one's complement in the high nibble.
- R3: In isochronous mode (`iso_i`=1), the PID byte is always 0xC3, whatever the value of `toggle_i`.
- R4: After the PID byte, each FIFO byte is sent as a valid byte in FIFO order, one per cycle. `fifo_rd_o` pops a byte only in the cycle in which that byte is taken.
- R5: When the FIFO is empty and `last_i` is set, the next two valid bytes are the CRC. The CRC is computed over the payload bytes only, LSB of each byte first, with polynomial 0x8005 and seed 0xFFFF. The complemented remainder is sent low byte first. For the ASCII payload "123456789" these two bytes are 0xC8, then 0xB4.
- R6: If `last_i` is set and the FIFO is empty when the packet starts, the block sends a zero-length packet. The output is the PID byte, then 0x00, then 0x00, then end-of-packet.
- R7: After a normal packet, end-of-packet follows in the cycle after the CRC high byte. In that cycle `eop_o`, `done_o` and `last_clr_o` are high and `aborted_o` is low.
- R8: If the FIFO is empty while `last_i` is clear after the PID byte, the block sends no CRC. It raises `stuff_err_o` for one cycle, and in the next cycle raises `eop_o`, `done_o` and `aborted_o`, with `last_clr_o` low.
- R9: Bytes written into the FIFO while the packet is being sent are transmitted in the same packet without a gap, as long as the FIFO does not run empty.
- R10: A start pulse while a packet is in progress has no effect. No second PID appears, and no output follows the end-of-packet until a new start arrives while idle.
- R11: At most one of `tx_valid_o`, `stuff_err_o` and `eop_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to send a packet |
| toggle_i | input | 1 | Data toggle; selects DATA1 when set in non-isochronous mode |
| iso_i | input | 1 | Isochronous endpoint; forces DATA0 |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| fifo_data_i | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_rd_o | output | 1 | Pop the FIFO head this cycle |
| last_i | input | 1 | Whole packet has been written into the FIFO |
| last_clr_o | output | 1 | Clear strobe for the last-byte flag |
| tx_byte_o | output | 8 | Outgoing packet byte |
| tx_valid_o | output | 1 | `tx_byte_o` carries a byte this cycle |
| stuff_err_o | output | 1 | Forced stuff error (abort) this cycle |
| eop_o | output | 1 | End-of-packet marker this cycle |
| done_o | output | 1 | Packet finished this cycle |
| aborted_o | output | 1 | With `done_o`: the packet was aborted by underrun |

## Verification
A CRC register that is seeded wrongly or skips a byte shows up only in the two CRC bytes at the end of the packet. The bench therefore compares every CRC byte against a separately built model and also against a known vector. A wrong phase in the state register appears one cycle after the fault as a missing or extra item: a second PID, a CRC after an underrun, or an end-of-packet without the last-byte clear strobe. The scoreboard flags these in the cycle where they occur. Since pops are tied to sent bytes, a pop fault leaves the FIFO not drained at the end of the packet.

// File: rtl/usb_ser_pkg.sv
package usb_ser_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam int PID_W  = 4;

    localparam logic [PID_W-1:0] PID_DATA0 = 4'b0011;
    localparam logic [PID_W-1:0] PID_DATA1 = 4'b1011;

    localparam logic [CRC_W-1:0] CRC_SEED      = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC_HI,
        ST_EOP,
        ST_ABORT
    } ser_state_e;

    typedef struct packed {
        ser_state_e        state;
        logic [CRC_W-1:0]  crc;
        logic [BYTE_W-1:0] tx_byte;
        logic              tx_valid;
        logic              stuff_err;
        logic              eop;
        logic              done;
        logic              aborted;
        logic              last_clr;
    } ser_regs_t;
endpackage

// File: rtl/usb_crc16_byte.sv
module usb_crc16_byte #(
    parameter int              W    = 16,
    parameter int              DW   = 8,
    parameter logic [W-1:0]    POLY = 16'hA001
) (
    input  logic [W-1:0]  crc_i,
    input  logic [DW-1:0] data_i,
    output logic [W-1:0]  crc_o
);
    always_comb begin
        logic [W-1:0] c;
        c = crc_i;
        for (int i = 0; i < DW; i++) begin
            if (c[0] ^ data_i[i]) begin
                c = (c >> 1) ^ POLY;
            end else begin
                c = c >> 1;
            end
        end
        crc_o = c;
    end
endmodule

// File: rtl/usb_pid_sel.sv
module usb_pid_sel
    import usb_ser_pkg::*;
(
    input  logic              toggle_i,
    input  logic              iso_i,
    output logic [BYTE_W-1:0] pid_byte_o
);
    logic [PID_W-1:0] code;

    always_comb begin
        code       = (toggle_i && !iso_i) ? PID_DATA1 : PID_DATA0;
        pid_byte_o = {~code, code};
    end
endmodule

// File: rtl/usb_data_pkt_ser.sv
module usb_data_pkt_ser
    import usb_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        toggle_i,
    input  logic        iso_i,
    input  logic        fifo_empty_i,
    input  logic [7:0]  fifo_data_i,
    output logic        fifo_rd_o,
    input  logic        last_i,
    output logic        last_clr_o,
    output logic [7:0]  tx_byte_o,
    output logic        tx_valid_o,
    output logic        stuff_err_o,
    output logic        eop_o,
    output logic        done_o,
    output logic        aborted_o
);
    ser_regs_t         r_q, r_d;
    logic [BYTE_W-1:0] pid_byte;
    logic [CRC_W-1:0]  crc_next;
    logic [CRC_W-1:0]  crc_fin;

    usb_pid_sel u_pid (
        .toggle_i   (toggle_i),
        .iso_i      (iso_i),
        .pid_byte_o (pid_byte)
    );

    usb_crc16_byte #(
        .W    (CRC_W),
        .DW   (BYTE_W),
        .POLY (CRC_POLY_REFL)
    ) u_crc (
        .crc_i  (r_q.crc),
        .data_i (fifo_data_i),
        .crc_o  (crc_next)
    );

    assign crc_fin = ~r_q.crc;

    always_comb begin
        r_d           = r_q;
        r_d.tx_valid  = 1'b0;
        r_d.stuff_err = 1'b0;
        r_d.eop       = 1'b0;
        r_d.done      = 1'b0;
        r_d.aborted   = 1'b0;
        r_d.last_clr  = 1'b0;
        fifo_rd_o     = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.crc      = CRC_SEED;
                    r_d.tx_byte  = pid_byte;
                    r_d.tx_valid = 1'b1;
                    r_d.state    = ST_DATA;
                end
            end
            ST_DATA: begin
                if (!fifo_empty_i) begin
                    fifo_rd_o    = 1'b1;
                    r_d.crc      = crc_next;
                    r_d.tx_byte  = fifo_data_i;
                    r_d.tx_valid = 1'b1;
                end else if (last_i) begin
                    r_d.tx_byte  = crc_fin[BYTE_W-1:0];
                    r_d.tx_valid = 1'b1;
                    r_d.state    = ST_CRC_HI;
                end else begin
                    r_d.stuff_err = 1'b1;
                    r_d.state     = ST_ABORT;
                end
            end
            ST_CRC_HI: begin
                r_d.tx_byte  = crc_fin[CRC_W-1:BYTE_W];
                r_d.tx_valid = 1'b1;
                r_d.state    = ST_EOP;
            end
            ST_EOP: begin
                r_d.eop      = 1'b1;
                r_d.done     = 1'b1;
                r_d.last_clr = 1'b1;
                r_d.state    = ST_IDLE;
            end
            ST_ABORT: begin
                r_d.eop     = 1'b1;
                r_d.done    = 1'b1;
                r_d.aborted = 1'b1;
                r_d.state   = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, crc: CRC_SEED, tx_byte: '0, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_byte_o   = r_q.tx_byte;
    assign tx_valid_o  = r_q.tx_valid;
    assign stuff_err_o = r_q.stuff_err;
    assign eop_o       = r_q.eop;
    assign done_o      = r_q.done;
    assign aborted_o   = r_q.aborted;
    assign last_clr_o  = r_q.last_clr;

    assert_strobes_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid_o, stuff_err_o, eop_o}));

    assert_pid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start_i) |=>
            (tx_valid_o && (tx_byte_o == 8'hC3 || tx_byte_o == 8'h4B)));

    assert_iso_data0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start_i && iso_i) |=> (tx_byte_o == 8'hC3));

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);

    assert_clr_on_clean_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_clr_o |-> (eop_o && done_o && !aborted_o));

    assert_stuff_then_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err_o |=> (eop_o && aborted_o && !last_clr_o));

    assert_eop_is_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> done_o);
endmodule

// File: tb/usb_data_pkt_ser_tb.sv
`timescale 1ns/1ps
module usb_data_pkt_ser_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, toggle = 1'b0, iso = 1'b0, last_flag = 1'b0;
    logic       fifo_rd, last_clr, tx_valid, stuff_err, eop, done, aborted;
    logic [7:0] tx_byte;

    logic [7:0] mem [256];
    logic [7:0] wr_ptr = 8'd0, rd_ptr = 8'd0;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_data  = mem[rd_ptr];

    int checks = 0, errors = 0;
    int         kq[$];
    logic [7:0] bq[$];
    string      tq[$];
    logic [7:0] pay[$];

    always #4 clk = ~clk;

    usb_data_pkt_ser u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .toggle_i(toggle), .iso_i(iso),
        .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
        .last_i(last_flag), .last_clr_o(last_clr), .tx_byte_o(tx_byte),
        .tx_valid_o(tx_valid), .stuff_err_o(stuff_err), .eop_o(eop),
        .done_o(done), .aborted_o(aborted)
    );

    always @(posedge clk) if (rst_n && fifo_rd) rd_ptr <= rd_ptr + 8'd1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference CRC: non-reflected register, bits fed LSB first, result reflected.
    function automatic logic [15:0] ref_crc();
        logic [15:0] c = 16'hFFFF;
        logic [15:0] r;
        foreach (pay[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[15] ^ pay[i][b];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h8005;
            end
        end
        for (int b = 0; b < 16; b++) r[b] = c[15-b];
        return ~r;
    endfunction

    // kind: 0 byte, 1 stuff error, 2 clean eop, 3 aborted eop
    task automatic exp_item(input int k, input logic [7:0] b, input string tag);
        kq.push_back(k); bq.push_back(b); tq.push_back(tag);
    endtask

    task automatic expect_pkt(input logic [7:0] pid, input bit abort, input string tag);
        logic [15:0] c;
        exp_item(0, pid, tag);
        foreach (pay[i]) exp_item(0, pay[i], "R4");
        if (abort) begin
            exp_item(1, 8'h00, "R8");
            exp_item(3, 8'h00, "R8");
        end else begin
            c = ref_crc();
            exp_item(0, c[7:0], "R5");
            exp_item(0, c[15:8], "R5");
            exp_item(2, 8'h00, "R7");
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (tx_valid || stuff_err || eop)) begin
            if (kq.size() == 0) begin
                chk(1'b0, "R10", "unexpected output", {tx_valid, stuff_err, eop}, 0);
            end else begin
                int k; logic [7:0] b; string t;
                k = kq.pop_front(); b = bq.pop_front(); t = tq.pop_front();
                case (k)
                    0: chk(tx_valid && tx_byte == b, t, "byte",
                           {tx_valid, tx_byte}, {1'b1, b});
                    1: chk(stuff_err && !tx_valid && !eop, t, "stuff error",
                           {tx_valid, stuff_err, eop}, 3'b010);
                    2: chk({eop, done, aborted, last_clr} == 4'b1101, t, "clean eop",
                           {eop, done, aborted, last_clr}, 4'b1101);
                    default: chk({eop, done, aborted, last_clr} == 4'b1110, t, "aborted eop",
                           {eop, done, aborted, last_clr}, 4'b1110);
                endcase
            end
        end
    end

    task automatic push_byte(input logic [7:0] b);
        mem[wr_ptr] = b;
        wr_ptr = wr_ptr + 8'd1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(done, tag, "packet completion", done, 1);
        @(negedge clk);
        last_flag = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_full(input bit tg, input bit is_iso, input logic [7:0] pid,
                             input string tag);
        @(negedge clk);
        foreach (pay[i]) push_byte(pay[i]);
        toggle = tg; iso = is_iso; last_flag = 1'b1;
        expect_pkt(pid, 1'b0, tag);
        pulse_start();
        wait_done(tag);
        chk(fifo_empty, "R4", "fifo drained", wr_ptr - rd_ptr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({tx_valid, stuff_err, eop, done, aborted, last_clr, fifo_rd} == 7'b0, "R1",
            "outputs in reset", {tx_valid, stuff_err, eop, done, aborted, last_clr, fifo_rd}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({tx_valid, stuff_err, eop, done, aborted, last_clr, fifo_rd} == 7'b0, "R1",
            "outputs after reset", {tx_valid, stuff_err, eop, done, aborted, last_clr, fifo_rd}, 0);

        pay = '{8'h01, 8'h02, 8'h03};
        send_full(1'b0, 1'b0, 8'hC3, "R2");

        pay = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        chk(ref_crc() == 16'hB4C8, "R5", "reference vector", ref_crc(), 16'hB4C8);
        send_full(1'b1, 1'b0, 8'h4B, "R2");

        pay = '{8'hA5, 8'h5A};
        send_full(1'b1, 1'b1, 8'hC3, "R3");
        pay = '{8'hFF};
        send_full(1'b0, 1'b1, 8'hC3, "R3");

        pay.delete();
        send_full(1'b1, 1'b0, 8'h4B, "R6");

        // Underrun: no last flag
        pay = '{8'h10, 8'h20, 8'h30};
        @(negedge clk);
        foreach (pay[i]) push_byte(pay[i]);
        toggle = 1'b0; iso = 1'b0; last_flag = 1'b0;
        expect_pkt(8'hC3, 1'b1, "R8");
        pulse_start();
        wait_done("R8");

        // Streaming with a start pulse mid-packet
        pay = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        @(negedge clk);
        toggle = 1'b1; iso = 1'b0; last_flag = 1'b0;
        expect_pkt(8'h4B, 1'b0, "R9");
        push_byte(pay[0]);
        start = 1'b1;
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            start = (i == 3);
            push_byte(pay[i]);
            if (i == 5) last_flag = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        chk(fifo_empty, "R9", "streamed fifo drained", wr_ptr - rd_ptr, 0);

        repeat (10) @(negedge clk);
        chk(kq.size() == 0, "R10", "scoreboard empty", kq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule